// File: doc/BRIEF.md
# Clock Branch Gate Sequencer

This block turns a single enable or disable request into a read-modify-write of one branch-enable bit. It then confirms that the branch has actually changed state before it reports completion. The requester presents the direction and the current contents of the enable register. The block returns the updated register word on a one-cycle write strobe. Only the bit at parameter `EN_BIT` is changed; every other bit keeps its value.

After the write, a confirmation policy is selected from a check-mode code, a voted flag, the request direction and a hardware-gating bit.
- Some policies complete at once.
- Some wait a fixed number of microsecond ticks.
- Some sample a clock-off status line on each tick until it shows the expected level, or until the poll budget runs out, which is a timeout error.

A branch with no enable register fails immediately and is never written. Completion is one `done` pulse, with `error` raised in the same cycle on failure.

Top module: `branch_gate_seq`

## Requirements
- R1: On acceptance of a request, `regWrEn` pulses for exactly one cycle in the following cycle. `regWrData` equals the `regRdData` sampled at acceptance with bit `EN_BIT` (default 0) replaced by `reqEnable` (1 = enable).
- R2: When `cfgHasEnReg` is 0 at acceptance, `done` and `error` are high in the cycle after acceptance and no write strobe is issued.
- R3: With `cfgMode` = 0 (skip) and `cfgVoted` = 0, `done` rises with `error` low in the cycle after the write strobe.
- R4: When `cfgHwGate` is 1 and the skip rule does not apply, completion happens as in R3, whatever the status input does. This rule is checked after skip and before the delay and poll rules.
- R5: With `cfgMode` = 1 (delay) and `cfgVoted` = 0, or for a disable with `cfgVoted` = 1, the block counts 10 `tickUs` pulses after the write. `done` rises without error in the cycle after the tenth.
- R6: With `cfgMode` = 2 (halt) or 3 (inverted halt) and `cfgVoted` = 0, or for an enable with `cfgVoted` = 1, the block samples `clkOffStatus` on each `tickUs` pulse after the write, at most 200 times.
- R7: A sample passes when `clkOffStatus` is 0 for an enable and 1 for a disable, in both halt modes. `done` rises without error in the cycle after a passing sample.
- R8: If 200 samples all fail, `done` and `error` rise together in the cycle after the 200th.
- R9: Mode codes 4 to 7 with `cfgVoted` = 0 complete as in R3.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. Requests that arrive while `busy` is high cause no write and no change of outcome.
- R11: `done` is a one-cycle pulse, and `error` is high only together with `done`.
- R12: A synchronous `rst` returns the block to idle, with `busy`, `done`, `error` and `regWrEn` low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickUs | input | 1 | Single-cycle microsecond strobe |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqEnable | input | 1 | 1 = enable branch, 0 = disable |
| cfgMode | input | 3 | Check mode: 0 skip, 1 delay, 2 halt, 3 inverted halt, others none |
| cfgVoted | input | 1 | Branch is voted |
| cfgHasEnReg | input | 1 | An enable register exists |
| cfgHwGate | input | 1 | Hardware clock gating active |
| clkOffStatus | input | 1 | Branch clock-off status |
| regRdData | input | REG_W | Current enable register contents |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | REG_W | Updated enable register word |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| error | output | 1 | Failure flag, valid with done |

## Verification
A wrong policy choice shows up at the ports a fixed number of cycles after the write strobe. It either completes a cycle after the write when it should have waited, or it waits ticks it should not. The per-clock comparison therefore flags it at the first diverging cycle. A counter that is off by one moves `done` by one tick period. A status compare with the wrong polarity turns a success into a 200-tick timeout, or the reverse. A corrupted latched word or direction is visible on `regWrData` in the cycle straight after acceptance.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_SKIP     = 3'd0;
  localparam logic [MODE_W-1:0] MODE_DELAY    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_HALT     = 3'd2;
  localparam logic [MODE_W-1:0] MODE_HALT_INV = 3'd3;

  typedef enum logic [1:0] {
    POL_NOREG = 2'd0,
    POL_NONE  = 2'd1,
    POL_DELAY = 2'd2,
    POL_POLL  = 2'd3
  } policy_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WRITE  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_POLL   = 3'd3,
    ST_FINISH = 3'd4
  } seqState_t;

  typedef struct packed {
    logic latchReq;
    logic cntClr;
    logic cntInc;
  } seqStrb_t;

endpackage

// File: rtl/branch_seq_policy.sv
module branch_seq_policy
  import branch_seq_pkg::*;
(
  input  logic              reqEnable,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              cfgVoted,
  input  logic              cfgHasEnReg,
  input  logic              cfgHwGate,
  output policy_t           policy
);

  logic isSkip;
  logic isDelay;
  logic isHaltAny;

  assign isSkip    = (cfgMode == MODE_SKIP);
  assign isDelay   = (cfgMode == MODE_DELAY);
  assign isHaltAny = (cfgMode == MODE_HALT) || (cfgMode == MODE_HALT_INV);

  always_comb begin
    if (!cfgHasEnReg) begin
      policy = POL_NOREG;
    end else if (isSkip && !cfgVoted) begin
      policy = POL_NONE;
    end else if (cfgHwGate) begin
      policy = POL_NONE;
    end else if ((isDelay && !cfgVoted) || (!reqEnable && cfgVoted)) begin
      policy = POL_DELAY;
    end else if ((isHaltAny && !cfgVoted) || (reqEnable && cfgVoted)) begin
      policy = POL_POLL;
    end else begin
      policy = POL_NONE;
    end
  end

endmodule

// File: rtl/branch_seq_datapath.sv
module branch_seq_datapath
  import branch_seq_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int EN_BIT      = 0,
  parameter int DELAY_TICKS = 10,
  parameter int POLL_LIMIT  = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrb_t         strb,
  input  logic             reqEnable,
  input  logic [REG_W-1:0] regRdData,
  input  logic             clkOffStatus,
  output logic [REG_W-1:0] wrData,
  output logic             delayEnd,
  output logic             pollEnd,
  output logic             statusGood
);

  localparam int MAX_CNT = (DELAY_TICKS > POLL_LIMIT) ? DELAY_TICKS : POLL_LIMIT;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(DELAY_TICKS - 1);
  localparam logic [CNT_W-1:0] POLL_LAST  = CNT_W'(POLL_LIMIT - 1);

  logic [REG_W-1:0] mergedWord;
  logic [REG_W-1:0] wordReg;
  logic             dirReg;
  logic [CNT_W-1:0] tickCnt;

  for (genvar b = 0; b < REG_W; b++) begin : g_merge
    if (b == EN_BIT) begin : g_en
      assign mergedWord[b] = reqEnable;
    end else begin : g_keep
      assign mergedWord[b] = regRdData[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordReg <= '0;
      dirReg  <= 1'b0;
    end else if (strb.latchReq) begin
      wordReg <= mergedWord;
      dirReg  <= reqEnable;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.cntClr) begin
      tickCnt <= '0;
    end else if (strb.cntInc) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign wrData     = wordReg;
  assign delayEnd   = (tickCnt == DELAY_LAST);
  assign pollEnd    = (tickCnt == POLL_LAST);
  assign statusGood = dirReg ? !clkOffStatus : clkOffStatus;

endmodule

// File: rtl/branch_seq_ctrl.sv
module branch_seq_ctrl
  import branch_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tickUs,
  input  logic     reqValid,
  input  policy_t  policy,
  input  logic     delayEnd,
  input  logic     pollEnd,
  input  logic     statusGood,
  output seqStrb_t strb,
  output logic     wrPulse,
  output logic     busy,
  output logic     done,
  output logic     error
);

  seqState_t state;
  seqState_t stateNext;
  policy_t   polReg;
  policy_t   polNext;
  logic      errReg;
  logic      errNext;

  always_comb begin
    stateNext = state;
    polNext   = polReg;
    errNext   = errReg;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.latchReq = 1'b1;
          polNext       = policy;
          if (policy == POL_NOREG) begin
            errNext   = 1'b1;
            stateNext = ST_FINISH;
          end else begin
            errNext   = 1'b0;
            stateNext = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        strb.cntClr = 1'b1;
        unique case (polReg)
          POL_DELAY: stateNext = ST_WAIT;
          POL_POLL:  stateNext = ST_POLL;
          default:   stateNext = ST_FINISH;
        endcase
      end
      ST_WAIT: begin
        if (tickUs) begin
          if (delayEnd) stateNext = ST_FINISH;
          else          strb.cntInc = 1'b1;
        end
      end
      ST_POLL: begin
        if (tickUs) begin
          if (statusGood) begin
            stateNext = ST_FINISH;
          end else if (pollEnd) begin
            errNext   = 1'b1;
            stateNext = ST_FINISH;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      polReg <= POL_NONE;
      errReg <= 1'b0;
    end else begin
      state  <= stateNext;
      polReg <= polNext;
      errReg <= errNext;
    end
  end

  assign wrPulse = (state == ST_WRITE);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FINISH);
  assign error   = (state == ST_FINISH) && errReg;

endmodule

// File: rtl/branch_gate_seq.sv
module branch_gate_seq
  import branch_seq_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int EN_BIT      = 0,
  parameter int DELAY_TICKS = 10,
  parameter int POLL_LIMIT  = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickUs,
  input  logic              reqValid,
  input  logic              reqEnable,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              cfgVoted,
  input  logic              cfgHasEnReg,
  input  logic              cfgHwGate,
  input  logic              clkOffStatus,
  input  logic [REG_W-1:0]  regRdData,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regWrData,
  output logic              busy,
  output logic              done,
  output logic              error
);

  policy_t  policy;
  seqStrb_t strb;
  logic     delayEnd;
  logic     pollEnd;
  logic     statusGood;

  branch_seq_policy u_policy (
    .reqEnable   (reqEnable),
    .cfgMode     (cfgMode),
    .cfgVoted    (cfgVoted),
    .cfgHasEnReg (cfgHasEnReg),
    .cfgHwGate   (cfgHwGate),
    .policy      (policy)
  );

  branch_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tickUs     (tickUs),
    .reqValid   (reqValid),
    .policy     (policy),
    .delayEnd   (delayEnd),
    .pollEnd    (pollEnd),
    .statusGood (statusGood),
    .strb       (strb),
    .wrPulse    (regWrEn),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  branch_seq_datapath #(
    .REG_W       (REG_W),
    .EN_BIT      (EN_BIT),
    .DELAY_TICKS (DELAY_TICKS),
    .POLL_LIMIT  (POLL_LIMIT)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .reqEnable    (reqEnable),
    .regRdData    (regRdData),
    .clkOffStatus (clkOffStatus),
    .wrData       (regWrData),
    .delayEnd     (delayEnd),
    .pollEnd      (pollEnd),
    .statusGood   (statusGood)
  );

endmodule

// File: rtl/branch_seq_checker.sv
module branch_seq_checker #(
  parameter int REG_W  = 32,
  parameter int EN_BIT = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             reqValid,
  input logic             reqEnable,
  input logic             cfgHasEnReg,
  input logic [REG_W-1:0] regRdData,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic             busy,
  input logic             done,
  input logic             error
);

  localparam logic [REG_W-1:0] KEEP_MASK = ~({{(REG_W-1){1'b0}}, 1'b1} << EN_BIT);

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    regWrEn |=> !regWrEn); // R1

  AST_WR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> ((regWrData & KEEP_MASK) == ($past(regRdData) & KEEP_MASK))); // R1

  AST_WR_BIT_DIR: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> (regWrData[EN_BIT] == $past(reqEnable))); // R1

  AST_NOREG_FAILS: assert property (@(posedge clk) disable iff (rst)
    (!busy && reqValid && !cfgHasEnReg) |=> (done && error && !regWrEn)); // R2

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && reqValid) |=> busy); // R10

  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> busy); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    error |-> done); // R11

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !done && !error && !regWrEn)); // R12

endmodule

bind branch_gate_seq branch_seq_checker #(
  .REG_W  (REG_W),
  .EN_BIT (EN_BIT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reqValid    (reqValid),
  .reqEnable   (reqEnable),
  .cfgHasEnReg (cfgHasEnReg),
  .regRdData   (regRdData),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .busy        (busy),
  .done        (done),
  .error       (error)
);

// File: tb/branch_gate_seq_bench.sv
module branch_gate_seq_bench;

  localparam int REG_W  = 32;
  localparam int EN_BIT = 5;
  localparam int TICK_DIV = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tickUs = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqEnable = 1'b0;
  logic [2:0]       cfgMode = 3'd0;
  logic             cfgVoted = 1'b0;
  logic             cfgHasEnReg = 1'b1;
  logic             cfgHwGate = 1'b0;
  logic             clkOffStatus = 1'b0;
  logic [REG_W-1:0] regRdData = '0;
  logic             regWrEn;
  logic [REG_W-1:0] regWrData;
  logic             busy;
  logic             done;
  logic             error;

  int    testsRun = 0;
  int    testsFailed = 0;
  string curTag = "R12";
  int    wrCount = 0;
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  branch_gate_seq #(.REG_W(REG_W), .EN_BIT(EN_BIT)) u_branch_gate_seq (
    .clk(clk), .rst(rst), .tickUs(tickUs), .reqValid(reqValid),
    .reqEnable(reqEnable), .cfgMode(cfgMode), .cfgVoted(cfgVoted),
    .cfgHasEnReg(cfgHasEnReg), .cfgHwGate(cfgHwGate),
    .clkOffStatus(clkOffStatus), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrData(regWrData), .busy(busy),
    .done(done), .error(error)
  );

  // Behavioural reference: 0 idle, 1 write, 2 delay, 3 poll, 4 finish
  int              mState = 0;
  int              mCnt = 0;
  int              mPol = 0;   // 0 none, 1 delay, 2 poll
  bit              mErr = 1'b0;
  bit              mDir = 1'b0;
  logic [REG_W-1:0] mWord = '0;

  always @(posedge clk) begin
    if (rst) begin
      mState = 0;
      mErr   = 1'b0;
    end else begin
      case (mState)
        0: if (reqValid) begin
          mDir = reqEnable;
          if (!cfgHasEnReg) begin
            mErr = 1'b1; mState = 4;
          end else begin
            mErr  = 1'b0;
            mWord = regRdData;
            mWord[EN_BIT] = reqEnable;
            if (cfgMode == 3'd0 && !cfgVoted)                      mPol = 0;
            else if (cfgHwGate)                                    mPol = 0;
            else if ((cfgMode == 3'd1 && !cfgVoted) || (!reqEnable && cfgVoted)) mPol = 1;
            else if (((cfgMode == 3'd2 || cfgMode == 3'd3) && !cfgVoted) || (reqEnable && cfgVoted)) mPol = 2;
            else                                                   mPol = 0;
            mState = 1;
          end
        end
        1: begin
          mCnt = 0;
          mState = (mPol == 0) ? 4 : (mPol == 1) ? 2 : 3;
        end
        2: if (tickUs) begin
          mCnt++;
          if (mCnt == 10) mState = 4;
        end
        3: if (tickUs) begin
          mCnt++;
          if (mDir ? (clkOffStatus == 1'b0) : (clkOffStatus == 1'b1)) mState = 4;
          else if (mCnt == 200) begin mErr = 1'b1; mState = 4; end
        end
        default: mState = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string what, input string tag,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (!finished) begin
      check(busy == (mState != 0), "busy", curTag, longint'(busy), longint'(mState != 0));
      check(done == (mState == 4), "done", curTag, longint'(done), longint'(mState == 4));
      check(error == (mState == 4 && mErr), "error", curTag, longint'(error), longint'(mState == 4 && mErr));
      check(regWrEn == (mState == 1), "regWrEn", curTag, longint'(regWrEn), longint'(mState == 1));
      if (mState == 1)
        check(regWrData == mWord, "regWrData R1", curTag, longint'(regWrData), longint'(mWord));
      if (regWrEn) wrCount++;
    end
  end

  // Tick strobe: one cycle high every TICK_DIV cycles
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % TICK_DIV;
      tickUs = (ph == 0);
    end
  end

  task automatic runReq(input bit en, input logic [2:0] mode, input bit voted,
                        input bit hasEn, input bit hw, input logic [REG_W-1:0] rd,
                        input bit offStart, input int flipAt, input bit expErr,
                        input int expMinWait, input int expMaxWait, input string tag);
    int waited = 0;
    curTag = tag;
    @(negedge clk);
    reqValid = 1'b1; reqEnable = en; cfgMode = mode; cfgVoted = voted;
    cfgHasEnReg = hasEn; cfgHwGate = hw; regRdData = rd; clkOffStatus = offStart;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
      if (waited == flipAt) clkOffStatus = ~offStart;
    end
    check(done == 1'b1, "done seen", tag, longint'(done), 1);
    check(error == expErr, "outcome", tag, longint'(error), longint'(expErr));
    check(waited >= expMinWait && waited <= expMaxWait, "latency", tag,
          longint'(waited), longint'(expMinWait));
    @(negedge clk);
  endtask

  initial begin
    int wrBefore;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!busy && !done && !error && !regWrEn, "reset idle R12", "R12",
          longint'({busy, done, error, regWrEn}), 0);
    rst = 1'b0;

    // R2: no enable register -> immediate error, no write
    wrBefore = wrCount;
    runReq(1, 3'd0, 0, 0, 0, 32'hFFFF_0000, 0, -1, 1, 0, 0, "R2");
    check(wrCount == wrBefore, "no write R2", "R2", longint'(wrCount - wrBefore), 0);

    // R1/R3: skip mode, read-modify-write with other bits preserved
    runReq(1, 3'd0, 0, 1, 0, 32'hA5A5_0000, 1, -1, 0, 1, 1, "R3");
    runReq(0, 3'd0, 0, 1, 0, 32'hFFFF_FFFF, 0, -1, 0, 1, 1, "R1");

    // R4: hardware gating bypasses a halt check whose status never passes
    runReq(1, 3'd2, 0, 1, 1, 32'h1234_5678, 1, -1, 0, 1, 1, "R4");
    // R4 also beats a voted enable
    runReq(1, 3'd1, 1, 1, 1, 32'h0, 1, -1, 0, 1, 1, "R4");

    // R5: delay mode, and voted disable in halt mode
    runReq(1, 3'd1, 0, 1, 0, 32'h0000_00F0, 1, -1, 0, 36, 44, "R5");
    runReq(0, 3'd2, 1, 1, 0, 32'hFFFF_FFFF, 0, -1, 0, 36, 44, "R5");

    // R6/R7: poll passes at once, after a few ticks, and in inverted mode
    runReq(1, 3'd2, 0, 1, 0, 32'h0, 0, -1, 0, 2, 6, "R7");
    runReq(1, 3'd2, 0, 1, 0, 32'h0, 1, 20, 0, 20, 26, "R7");
    runReq(0, 3'd3, 0, 1, 0, 32'hFFFF_FFFF, 0, 13, 0, 13, 19, "R7");
    runReq(1, 3'd0, 1, 1, 0, 32'h0, 0, -1, 0, 2, 6, "R6");

    // R8: poll timeout
    runReq(1, 3'd2, 0, 1, 0, 32'h0, 1, -1, 1, 796, 804, "R8");

    // R9: unused mode code completes without waiting
    runReq(0, 3'd6, 0, 1, 0, 32'h8000_0020, 1, -1, 0, 1, 1, "R9");

    // R10: a request arriving while busy is ignored
    curTag = "R10";
    wrBefore = wrCount;
    @(negedge clk);
    reqValid = 1'b1; reqEnable = 1'b1; cfgMode = 3'd1; cfgVoted = 1'b0;
    cfgHasEnReg = 1'b1; cfgHwGate = 1'b0; regRdData = 32'h0;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    reqValid = 1'b1; reqEnable = 1'b0; cfgMode = 3'd0; regRdData = 32'hFFFF_FFFF;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "still busy R10", "R10", longint'(busy), 1);
    while (!done) @(negedge clk);
    check(error == 1'b0, "outcome R10", "R10", longint'(error), 0);
    @(negedge clk);
    check(wrCount - wrBefore == 1, "single write R10", "R10", longint'(wrCount - wrBefore), 1);

    // R12: reset in the middle of a delay wait
    curTag = "R12";
    @(negedge clk);
    reqValid = 1'b1; reqEnable = 1'b1; cfgMode = 3'd1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!busy && !done && !regWrEn, "mid reset R12", "R12",
          longint'({busy, done, regWrEn}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    finished = 1'b1;
    testsRun++;
    testsFailed++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule